// File: doc/BRIEF.md
# Byte-swap and sign-extend unit

This is a 64-bit execution unit. It handles two kinds of operation: byte and halfword rearrangement, and sign extension from a byte or a halfword. Each cycle it can accept one instruction word together with the source operand already read from the register file. It decodes the operation and returns the result one clock later on a registered output, with the destination register index alongside.

Decoding uses the major opcode, the source-register field, the 6-bit function code and the 5-bit shift-amount field, which acts as a sub-selector. An encoding the unit does not recognise raises an illegal flag instead of a write strobe, and so does a doubleword operation issued while 64-bit operation is disabled. Reading registers, forwarding results and taking the resulting trap are left to the surrounding pipeline.

Internally a small state machine has three states:
- `ST_IDLE`: no result this cycle.
- `ST_DONE`: a legal result is presented.
- `ST_FAULT`: an illegal encoding is reported.

It takes the same three transitions from every state:
- **go_idle**: when `in_valid` is low.
- **go_done**: when `in_valid` is high and the decode is legal.
- **go_fault**: when `in_valid` is high and the decode is illegal.

Top module: `hwswap_sext_unit`

## Requirements
- R1: The instruction word is split into the following fields. Only the first one, `instr[31:26]`, must equal 6'b011111 for any operation to be recognised; any other value there is illegal.
  - `instr[31:26]`: major opcode
  - `instr[25:21]`: source-register field
  - `instr[20:16]`: operand register
  - `instr[15:11]`: destination register
  - `instr[10:6]`: selector (shift-amount field)
  - `instr[5:0]`: function code
- R2: Function 6'b100000 with selector 5'b00010 swaps the two bytes inside each of the two low halfwords. The resulting 32-bit value is then sign-extended from its bit 31 to 64 bits.
- R3: Function 6'b100100 with selector 5'b00010 swaps the two bytes inside each of the four halfwords, and leaves every halfword in its position.
- R4: Function 6'b100100 with selector 5'b00101 reverses the halfword order. Output halfword k takes input halfword 3-k.
- R5: Function 6'b100000 with selector 5'b10000 copies operand bit 7 into result bits 63:8, and keeps bits 7:0.
- R6: Function 6'b100000 with selector 5'b11000 copies operand bit 15 into result bits 63:16, and keeps bits 15:0.
- R7: Each of the following raises `out_illegal`, holds `out_valid` low and drives `out_result` to zero:
  - a nonzero source-register field;
  - any other selector under function 6'b100000 or 6'b100100;
  - any other function code.
- R8: When `en64` is low, the two operations under function 6'b100100 are illegal. The three operations under function 6'b100000 work whatever the value of `en64`.
- R9: An accepted instruction produces its outcome one clock later. Back-to-back instructions produce back-to-back outcomes. On a legal outcome, `out_dest` carries the destination register field.
- R10: After reset, and in any cycle that follows a cycle with `in_valid` low, `out_valid` and `out_illegal` are both low and `out_result` is zero, whatever the instruction word was.
- R11: `out_valid` and `out_illegal` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operand are present |
| instr | input | 32 | Instruction word |
| rt_val | input | 64 | Source operand value |
| en64 | input | 1 | 64-bit operations are enabled |
| out_valid | output | 1 | Legal result present (write strobe) |
| out_illegal | output | 1 | Illegal encoding reported |
| out_result | output | 64 | Result value, zero unless out_valid |
| out_dest | output | 5 | Destination register index |

## Verification
The hardest situation to reach from the ports is a doubleword operation that is correctly encoded but turns illegal only because `en64` is low. It has to be told apart from a 32-bit operation under the same low `en64`, which must still succeed. The vector table changes `en64` from entry to entry and runs the same selector codes under both settings. Directed runs then send back-to-back instructions that alternate legal and illegal outcomes, which shows that the state machine switches straight between `ST_DONE` and `ST_FAULT` without passing through `ST_IDLE`.

// File: rtl/bsx_pkg.sv
package bsx_pkg;
    localparam int XLEN  = 64;
    localparam int HALF  = 16;
    localparam int BYTE  = 8;
    localparam int LANES = XLEN / HALF;
    localparam int REGW  = 5;

    localparam logic [5:0] MAJOR_OP  = 6'b011111;
    localparam logic [5:0] FN_WORD   = 6'b100000;
    localparam logic [5:0] FN_DWORD  = 6'b100100;
    localparam logic [4:0] SEL_SWAP  = 5'b00010;
    localparam logic [4:0] SEL_HREV  = 5'b00101;
    localparam logic [4:0] SEL_SEXT8 = 5'b10000;
    localparam logic [4:0] SEL_SEXT16= 5'b11000;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SWAP32,
        OP_SWAP64,
        OP_HREV64,
        OP_SEXT8,
        OP_SEXT16
    } bsx_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DONE,
        ST_FAULT
    } bsx_state_e;
endpackage

// File: rtl/bsx_decode.sv
module bsx_decode
    import bsx_pkg::*;
(
    input  logic [5:0] major,
    input  logic [4:0] src_field,
    input  logic [4:0] sel,
    input  logic [5:0] fn,
    input  logic       en64,
    output bsx_op_e    op,
    output logic       legal
);
    logic wide;

    always_comb begin
        op   = OP_NONE;
        wide = 1'b0;
        if (major == MAJOR_OP && src_field == '0) begin
            case (fn)
                FN_WORD: begin
                    case (sel)
                        SEL_SWAP:   op = OP_SWAP32;
                        SEL_SEXT8:  op = OP_SEXT8;
                        SEL_SEXT16: op = OP_SEXT16;
                        default:    op = OP_NONE;
                    endcase
                end
                FN_DWORD: begin
                    wide = 1'b1;
                    case (sel)
                        SEL_SWAP: op = OP_SWAP64;
                        SEL_HREV: op = OP_HREV64;
                        default:  op = OP_NONE;
                    endcase
                end
                default: op = OP_NONE;
            endcase
        end
        legal = (op != OP_NONE) && !(wide && !en64);
    end
endmodule

// File: rtl/bsx_datapath.sv
module bsx_datapath
    import bsx_pkg::*;
(
    input  logic [XLEN-1:0] src,
    input  bsx_op_e         op,
    output logic [XLEN-1:0] res
);
    logic [XLEN-1:0] swapped;
    logic [XLEN-1:0] reversed;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign swapped[i*HALF +: HALF]  = {src[i*HALF +: BYTE], src[i*HALF+BYTE +: BYTE]};
        assign reversed[i*HALF +: HALF] = src[(LANES-1-i)*HALF +: HALF];
    end

    always_comb begin
        unique case (op)
            OP_SWAP32: res = {{(XLEN-32){swapped[31]}}, swapped[31:0]};
            OP_SWAP64: res = swapped;
            OP_HREV64: res = reversed;
            OP_SEXT8:  res = {{(XLEN-BYTE){src[BYTE-1]}}, src[BYTE-1:0]};
            OP_SEXT16: res = {{(XLEN-HALF){src[HALF-1]}}, src[HALF-1:0]};
            default:   res = '0;
        endcase
    end
endmodule

// File: rtl/hwswap_sext_unit.sv
module hwswap_sext_unit
    import bsx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rt_val,
    input  logic            en64,
    output logic            out_valid,
    output logic            out_illegal,
    output logic [XLEN-1:0] out_result,
    output logic [REGW-1:0] out_dest
);
    bsx_state_e      state, state_nxt;
    bsx_op_e         dec_op;
    logic            dec_legal;
    logic [XLEN-1:0] dp_res;
    logic            unused_opnd;

    assign unused_opnd = ^instr[20:16];

    bsx_decode u_dec (
        .major    (instr[31:26]),
        .src_field(instr[25:21]),
        .sel      (instr[10:6]),
        .fn       (instr[5:0]),
        .en64     (en64),
        .op       (dec_op),
        .legal    (dec_legal)
    );

    bsx_datapath u_dp (
        .src(rt_val),
        .op (dec_op),
        .res(dp_res)
    );

    always_comb begin
        unique case (state)
            ST_IDLE, ST_DONE, ST_FAULT: begin
                if (!in_valid)      state_nxt = ST_IDLE;
                else if (dec_legal) state_nxt = ST_DONE;
                else                state_nxt = ST_FAULT;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result <= '0;
            out_dest   <= '0;
        end else if (in_valid && dec_legal) begin
            out_result <= dp_res;
            out_dest   <= instr[15:11];
        end else begin
            out_result <= '0;
            out_dest   <= '0;
        end
    end

    always_comb begin
        unique case (state)
            ST_DONE:  begin out_valid = 1'b1; out_illegal = 1'b0; end
            ST_FAULT: begin out_valid = 1'b0; out_illegal = 1'b1; end
            default:  begin out_valid = 1'b0; out_illegal = 1'b0; end
        endcase
    end
endmodule

// File: rtl/bsx_unit_checker.sv
module bsx_unit_checker
    import bsx_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [31:0]     instr,
    input logic [XLEN-1:0] rt_val,
    input logic            en64,
    input logic            out_valid,
    input logic            out_illegal,
    input logic [XLEN-1:0] out_result,
    input logic [REGW-1:0] out_dest
);
    logic is_wide, is_sext8, rs_bad;
    assign is_wide  = instr[31:26] == MAJOR_OP && instr[25:21] == '0 && instr[5:0] == FN_DWORD;
    assign is_sext8 = instr[31:26] == MAJOR_OP && instr[25:21] == '0 && instr[5:0] == FN_WORD
                      && instr[10:6] == SEL_SEXT8;
    assign rs_bad   = instr[25:21] != '0;

    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, out_illegal}));                                       // R11
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid || out_illegal));                                  // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_illegal && out_result == '0));           // R10
    AST_NO_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_wide && !en64) |=> out_illegal);                           // R8
    AST_RS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rs_bad) |=> (out_illegal && out_result == '0));               // R7
    AST_SEXT8_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_sext8) |=> (out_result[XLEN-1:BYTE] == {(XLEN-BYTE){$past(rt_val[BYTE-1])}})); // R5
    AST_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !rs_bad) |=> (!out_valid || out_dest == $past(instr[15:11])));  // R9
endmodule

bind hwswap_sext_unit bsx_unit_checker u_chk (.*);

// File: tb/hwswap_sext_unit_bench.sv
module hwswap_sext_unit_bench;
    localparam int N = 16;
    localparam logic [63:0] D1 = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] D2 = 64'hFEDC_BA98_7654_3210;

    localparam logic [5:0]  V_MAJ [N] = '{6'h1F,6'h1F,6'h1F,6'h1F,6'h1F,6'h1F,6'h1F,6'h1F,
                                          6'h1F,6'h1F,6'h1F,6'h1F,6'h1F,6'h1F,6'h1E,6'h1F};
    localparam logic [4:0]  V_RS  [N] = '{0,0,0,0,0,0,0,0,0,0,0,0,0,1,0,0};
    localparam logic [4:0]  V_SEL [N] = '{5'b00010,5'b00010,5'b00010,5'b00010,5'b00101,5'b00101,
                                          5'b10000,5'b10000,5'b11000,5'b11000,5'b00010,5'b00101,
                                          5'b00011,5'b00010,5'b00010,5'b00010};
    localparam logic [5:0]  V_FN  [N] = '{6'b100000,6'b100000,6'b100100,6'b100100,6'b100100,6'b100100,
                                          6'b100000,6'b100000,6'b100000,6'b100000,6'b100100,6'b100100,
                                          6'b100000,6'b100000,6'b100000,6'b100001};
    localparam logic        V_EN  [N] = '{1,0,1,1,1,1,0,1,1,0,0,0,1,1,1,1};
    localparam logic [63:0] V_SRC [N] = '{D1,D2,D1,D2,D1,D2,D1,D2,D1,D2,D1,D1,D1,D1,D1,D1};
    localparam logic [63:0] V_EXP [N] = '{64'hFFFF_FFFF_AB89_EFCD, 64'h0000_0000_5476_1032,
                                          64'h2301_6745_AB89_EFCD, 64'hDCFE_98BA_5476_1032,
                                          64'hCDEF_89AB_4567_0123, 64'h3210_7654_BA98_FEDC,
                                          64'hFFFF_FFFF_FFFF_FFEF, 64'h0000_0000_0000_0010,
                                          64'hFFFF_FFFF_FFFF_CDEF, 64'h0000_0000_0000_3210,
                                          64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0};
    localparam logic        V_ILL [N] = '{0,0,0,0,0,0,0,0,0,0,1,1,1,1,1,1};
    localparam string       V_REQ [N] = '{"R2","R2/R8","R3","R3","R4","R4","R5/R8","R5","R6","R6/R8",
                                          "R8","R8","R7","R7","R1","R7"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] rt_val = '0;
    logic        en64 = 1'b0;
    logic        out_valid, out_illegal;
    logic [63:0] out_result;
    logic [4:0]  out_dest;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    hwswap_sext_unit u_hwswap_sext_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .rt_val(rt_val),
        .en64(en64), .out_valid(out_valid), .out_illegal(out_illegal),
        .out_result(out_result), .out_dest(out_dest)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input int i, input logic [4:0] rd);
        in_valid = 1'b1;
        instr    = {V_MAJ[i], V_RS[i], 5'd3, rd, V_SEL[i], V_FN[i]};
        rt_val   = V_SRC[i];
        en64     = V_EN[i];
    endtask

    task automatic expect_vec(input int i, input logic [4:0] rd);
        check({V_REQ[i], " valid"},   64'(out_valid),   64'(!V_ILL[i]));
        check({V_REQ[i], " illegal"}, 64'(out_illegal), 64'(V_ILL[i]));
        check({V_REQ[i], " result"},  out_result,       V_EXP[i]);
        if (!V_ILL[i]) check("R9 dest", 64'(out_dest), 64'(rd));
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset valid",   64'(out_valid),   64'd0);
        check("R10 reset illegal", 64'(out_illegal), 64'd0);
        check("R10 reset result",  out_result,       64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            drive(i, 5'(i + 1));
            @(negedge clk);
            in_valid = 1'b0;
            expect_vec(i, 5'(i + 1));
        end

        // R9: back-to-back alternating legal / illegal / legal
        @(negedge clk); drive(4, 5'd20);
        @(negedge clk); expect_vec(4, 5'd20);  drive(12, 5'd21);
        @(negedge clk); expect_vec(12, 5'd21); drive(0, 5'd22);
        @(negedge clk); expect_vec(0, 5'd22);  in_valid = 1'b0;

        // R10: legal instruction word presented without in_valid is ignored
        instr  = {6'b011111, 5'd0, 5'd3, 5'd9, 5'b00010, 6'b100000};
        rt_val = D1;
        @(negedge clk);
        check("R10 no-valid strobe",  64'(out_valid),   64'd0);
        check("R10 no-valid illegal", 64'(out_illegal), 64'd0);
        check("R10 no-valid result",  out_result,       64'd0);

        // R11: exclusivity sampled on an illegal outcome
        drive(10, 5'd1);
        @(negedge clk); in_valid = 1'b0;
        check("R11 exclusive", 64'(out_valid & out_illegal), 64'd0);

        // R10: reset right after a legal result clears everything
        drive(2, 5'd7);
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        check("R10 reset after op valid",  64'(out_valid), 64'd0);
        check("R10 reset after op result", out_result,     64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule